// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Integer Adder

This block adds or subtracts two wide integer words. On each operation a lane-mode input decides how the word is split: it can be many narrow lanes, half as many lanes of twice the width, or a quarter as many lanes of four times the width. With the default parameters the word is 128 bits and the splits are eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. All lanes run the same operation in the same cycle, and one adder serves every lane width.

The datapath is a single ripple of fixed-width segments. A mask decoded from the mode cuts the carry at the edge of every active lane. At each cut the segment takes the operation's carry-in instead of its neighbour's carry-out: 0 for add and 1 for subtract. For subtraction operand B is inverted. The sum and one carry-out per lane are registered, so results appear one cycle after the operation is accepted.

Top module: `simd_part_adder`

## Requirements
- R1: `lane_mode` selects the lane width: 2'b00 gives lanes of SEG_W bits, 2'b01 gives lanes of 2*SEG_W bits and 2'b10 gives lanes of 4*SEG_W bits. Lane i occupies bits [i*w +: w], with lane 0 at the least significant end.
- R2: With `sub_en` = 0, every lane of `out_sum` equals (A_lane + B_lane) mod 2^w. No carry crosses a lane edge.
- R3: With `sub_en` = 1, every lane of `out_sum` equals (A_lane - B_lane) mod 2^w. This is formed as A + ~B + 1 inside each lane.
- R4: `out_carry[i]` is the carry out of the top bit of lane i. For add it is 1 on unsigned overflow. For subtract it is 1 when A_lane >= B_lane (unsigned).
- R5: `out_carry` bits at positions at or above the active lane count are 0.
- R6: The reserved encoding 2'b11 behaves exactly like 2'b10.
- R7: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R8: While `in_valid` is low, `out_sum` and `out_carry` keep their previous values.
- R9: During and after reset, before any accepted operation, `out_valid`, `out_sum` and `out_carry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_a | input | DATA_W | Operand A |
| op_b | input | DATA_W | Operand B |
| lane_mode | input | 2 | Lane width select |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| out_valid | output | 1 | Registered result is fresh |
| out_sum | output | DATA_W | Per-lane sum or difference |
| out_carry | output | DATA_W/SEG_W | Per-lane carry-out |

## Verification
The bench builds the block with DATA_W = 32 and SEG_W = 4. This keeps the same eight-segment structure and the same mode decoding as the default, but lanes become 4, 8 and 16 bits wide. Two bytes are spread across the word in several forms to make the operands. All 256 values of the first byte are crossed with 32 values of the second, in every mode including the reserved one and for both add and subtract. The narrowest lanes are therefore covered exhaustively, and every lane edge sees carries both arriving and not arriving.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    LM_NARROW = 2'b00,
    LM_MID    = 2'b01,
    LM_WIDE   = 2'b10,
    LM_RSVD   = 2'b11
  } lane_mode_e;

  // Number of segments that make up one lane in the given mode.
  function automatic int unsigned seg_span(input lane_mode_e m);
    case (m)
      LM_NARROW: seg_span = 1;
      LM_MID:    seg_span = 2;
      default:   seg_span = 4;
    endcase
  endfunction

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             invert_b,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout
);

  logic [SEG_W-1:0] b_eff;
  logic [SEG_W:0]   total;

  always_comb begin
    b_eff = b ^ {SEG_W{invert_b}};
    total = {1'b0, a} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin};
    sum   = total[SEG_W-1:0];
    cout  = total[SEG_W];
  end

endmodule

// File: rtl/simd_lane_bounds.sv
module simd_lane_bounds
  import simd_add_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  lane_mode_e      mode,
  output logic [NSEG-1:0] lane_start
);

  // A segment starts a lane when its index is a multiple of the lane span.
  for (genvar k = 0; k < NSEG; k++) begin : g_bound
    always_comb begin
      case (mode)
        LM_NARROW: lane_start[k] = 1'b1;
        LM_MID:    lane_start[k] = ((k % 2) == 0);
        default:   lane_start[k] = ((k % 4) == 0);
      endcase
    end
  end

endmodule

// File: rtl/simd_carry_gather.sv
module simd_carry_gather
  import simd_add_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  lane_mode_e      mode,
  input  logic [NSEG-1:0] seg_cout,
  output logic [NSEG-1:0] lane_cout
);

  localparam int N_MID  = NSEG / 2;
  localparam int N_WIDE = NSEG / 4;

  for (genvar i = 0; i < NSEG; i++) begin : g_lane
    logic c_mid;
    logic c_wide;

    if (i < N_MID) begin : g_mid
      assign c_mid = seg_cout[2*i+1];
    end else begin : g_mid_off
      assign c_mid = 1'b0;
    end

    if (i < N_WIDE) begin : g_wide
      assign c_wide = seg_cout[4*i+3];
    end else begin : g_wide_off
      assign c_wide = 1'b0;
    end

    always_comb begin
      case (mode)
        LM_NARROW: lane_cout[i] = seg_cout[i];
        LM_MID:    lane_cout[i] = c_mid;
        default:   lane_cout[i] = c_wide;
      endcase
    end
  end

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_add_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        op_a,
  input  logic [DATA_W-1:0]        op_b,
  input  logic [1:0]               lane_mode,
  input  logic                     sub_en,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_sum,
  output logic [DATA_W/SEG_W-1:0]  out_carry
);

  localparam int NSEG = DATA_W / SEG_W;

  lane_mode_e      mode;
  logic [NSEG-1:0] lane_start;
  logic [NSEG-1:0] seg_cin;
  logic [NSEG-1:0] seg_cout;
  logic [NSEG-1:0] lane_cout;
  logic [DATA_W-1:0] sum_c;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] sum_d,   sum_q;
  logic [NSEG-1:0]   carry_d, carry_q;

  assign mode = lane_mode_e'(lane_mode);

  simd_lane_bounds #(.NSEG(NSEG)) u_bounds (
    .mode       (mode),
    .lane_start (lane_start)
  );

  // One carry chain through all segments, cut at every lane start.
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign seg_cin[k] = sub_en;
    end else begin : g_next
      assign seg_cin[k] = lane_start[k] ? sub_en : seg_cout[k-1];
    end

    simd_seg_add #(.SEG_W(SEG_W)) u_seg (
      .a        (op_a[k*SEG_W +: SEG_W]),
      .b        (op_b[k*SEG_W +: SEG_W]),
      .invert_b (sub_en),
      .cin      (seg_cin[k]),
      .sum      (sum_c[k*SEG_W +: SEG_W]),
      .cout     (seg_cout[k])
    );
  end

  simd_carry_gather #(.NSEG(NSEG)) u_gather (
    .mode      (mode),
    .seg_cout  (seg_cout),
    .lane_cout (lane_cout)
  );

  // Next state: capture on accepted operation, hold otherwise.
  always_comb begin
    valid_d = in_valid;
    sum_d   = sum_q;
    carry_d = carry_q;
    if (in_valid) begin
      sum_d   = sum_c;
      carry_d = lane_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      carry_q <= '0;
    end else begin
      valid_q <= valid_d;
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  assign out_valid = valid_q;
  assign out_sum   = sum_q;
  assign out_carry = carry_q;

endmodule

// File: rtl/simd_part_adder_chk.sv
module simd_part_adder_chk #(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [DATA_W-1:0]        op_a,
  input logic [DATA_W-1:0]        op_b,
  input logic [1:0]               lane_mode,
  input logic                     sub_en,
  input logic                     out_valid,
  input logic [DATA_W-1:0]        out_sum,
  input logic [DATA_W/SEG_W-1:0]  out_carry
);

  localparam int NSEG = DATA_W / SEG_W;

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sum) && $stable(out_carry)));

  // R2
  add_zero_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_en && op_b == '0) |=>
      (out_sum == $past(op_a) && out_carry == '0));

  // R3
  sub_zero_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_en && op_b == '0 && lane_mode == 2'b00) |=>
      (out_sum == $past(op_a) && out_carry == '1));

  // R5
  mid_upper_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode == 2'b01) |=> (out_carry[NSEG-1:NSEG/2] == '0));

  // R6
  wide_upper_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode[1]) |=> (out_carry[NSEG-1:NSEG/4] == '0));

endmodule

bind simd_part_adder simd_part_adder_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .lane_mode (lane_mode),
  .sub_en    (sub_en),
  .out_valid (out_valid),
  .out_sum   (out_sum),
  .out_carry (out_carry)
);

// File: tb/tb_simd_part_adder.sv
module tb_simd_part_adder;

  localparam int DW = 32;
  localparam int SW = 4;
  localparam int NS = DW / SW;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] op_a, op_b;
  logic [1:0]    lane_mode;
  logic          sub_en;
  logic          out_valid;
  logic [DW-1:0] out_sum;
  logic [NS-1:0] out_carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  simd_part_adder #(.DATA_W(DW), .SEG_W(SW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .lane_mode (lane_mode),
    .sub_en    (sub_en),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_carry (out_carry)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent per-lane model of the requirements.
  task automatic ref_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [1:0] m, input logic s,
                        output logic [DW-1:0] r, output logic [NS-1:0] c);
    int span;
    int w;
    int n;
    longint unsigned mask;
    span = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    w    = span * SW;
    n    = NS / span;
    mask = (64'd1 << w) - 1;
    r = '0;
    c = '0;
    for (int i = 0; i < n; i++) begin
      longint unsigned ea, eb, t;
      ea = (longint'(a) >> (i * w)) & mask;
      eb = (longint'(b) >> (i * w)) & mask;
      t  = s ? (ea + ((~eb) & mask) + 1) : (ea + eb);
      r  = r | (DW'(t & mask) << (i * w));
      c[i] = ((t >> w) & 1) != 0;
    end
  endtask

  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [1:0] m, input logic s);
    logic [DW-1:0] er;
    logic [NS-1:0] ec;
    @(negedge clk);
    op_a = a; op_b = b; lane_mode = m; sub_en = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_op(a, b, m, s, er, ec);
    if (m == 2'b11) begin
      check("R6 sum", 64'(out_sum), 64'(er));
      check("R6/R4/R5 carry", 64'(out_carry), 64'(ec));
    end else if (s) begin
      check("R1/R3 sum", 64'(out_sum), 64'(er));
      check("R4/R5 carry", 64'(out_carry), 64'(ec));
    end else begin
      check("R1/R2 sum", 64'(out_sum), 64'(er));
      check("R4/R5 carry", 64'(out_carry), 64'(ec));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 180000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=<180000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; lane_mode = 2'b00; sub_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", 64'(out_valid), 64'd0);
    check("R9 sum", 64'(out_sum), 64'd0);
    check("R9 carry", 64'(out_carry), 64'd0);

    // R7 latency and R8 hold
    @(negedge clk);
    op_a = 32'h1234_5678; op_b = 32'h1111_1111; lane_mode = 2'b00; sub_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R7 valid high", 64'(out_valid), 64'd1);
    held = out_sum;
    in_valid = 1'b0; op_a = 32'hFFFF_FFFF; op_b = 32'h0F0F_0F0F; sub_en = 1'b1;
    @(negedge clk);
    check("R7 valid low", 64'(out_valid), 64'd0);
    check("R8 sum held", 64'(out_sum), 64'(held));
    check("R8 carry held", 64'(out_carry), 64'd0);

    // Directed lane-edge cases: carry stops at each lane edge (R2), borrow too (R3)
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0);
    run_op(32'hFFFF_FFFF, 32'h0101_0101, 2'b01, 1'b0);
    run_op(32'h0000_0000, 32'h0001_0001, 2'b10, 1'b1);
    run_op(32'h0000_0000, 32'h0000_0001, 2'b11, 1'b1);

    // Near-exhaustive sweep over all modes and both operations
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int x = 0; x < 256; x++) begin
          for (int yi = 0; yi < 32; yi++) begin
            logic [7:0] xb, yb;
            xb = 8'(x);
            yb = 8'(yi * 8 + (x % 8));
            run_op({xb, ~xb, xb ^ 8'h3C, {xb[3:0], xb[7:4]}},
                   {yb ^ 8'hA5, yb, ~yb, {yb[0], yb[7:1]}},
                   2'(m), 1'(s));
          end
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule